// File: doc/BRIEF.md
# Lockable Countdown Reset Watchdog

This block is a countdown watchdog that runs from a slow timebase. A 32768 Hz tick reaches it as a one-cycle enable strobe in the bus clock domain. Software loads a 32-bit timeout as two 16-bit halves and sets a run bit. From then on the counter steps down once per tick. When the count runs out, the block does one of two things. If reset-on-expiry is enabled, it raises a system reset request for one tick period and writes a watchdog cause code into a reset-status register. Otherwise it only sets a sticky expired flag.

The timing registers are guarded against stray writes. Load and control writes are thrown away until an unlock key has been written to the lock register. Writing any value other than the key to that register closes the guard again. Two enable registers, one for the module and one for its clock, must both have their enable bit set before the counter advances. A typical shutdown sequence does the following in order:
- unlock the registers;
- load a short timeout, such as 1638 ticks for 50 ms;
- set run together with reset-enable;
- lock the registers again.

Top module: `wdt_lockable_reset`

## Requirements
- R1: After reset the registers are locked (read value 1), the load halves, control and reset status read 0, and `sys_rst_req` and `expired` are low.
- R2: A write of 16'hE551 to the lock register (offset 0x20) unlocks. A write of any other value to it, including 16'h1AAE, locks. While locked, writes to offsets 0x00, 0x04 and 0x08 are discarded. Bit 0 read at 0x20 is 1 when locked.
- R3: The load value is {high half at 0x04, low half at 0x00}. The control register at 0x08 holds run (bit 1), new-load mode (bit 2) and reset-enable (bit 3), and reads back the expired flag at bit 4. Module enable (0x24), clock enable (0x28) and reset status (0x2C) ignore the lock. A read returns data one clock after `rd_en`.
- R4: The counter advances on a tick only while bit 2 is set in both the module-enable and the clock-enable register.
- R5: A 0-to-1 change of run reloads the counter from the full 32-bit load value. Expiry happens on the N-th enabled tick for a load of N, and on the first tick for a load of 0.
- R6: On expiry with reset-enable set, `sys_rst_req` rises at that tick's clock edge and falls at the next tick's edge. Hardware clears the run bit at the same edge.
- R7: On a reset-causing expiry, the low byte of the reset-status register becomes 8'hF0 and the high byte is kept. An expiry without reset leaves the register unchanged.
- R8: On expiry with reset-enable clear, `expired` and control bit 4 become 1 and stay 1 over later ticks, with no reset request. The next 0-to-1 change of run clears them.
- R9: With run and new-load mode set, an accepted write to the load-low register reloads the counter one clock later from the updated load value. Without new-load mode, such a write does not change a countdown already in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle 32 kHz timebase strobe |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 6 | Write byte offset |
| wr_data | input | 16 | Write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 6 | Read byte offset |
| rd_data | output | 16 | Read data, registered |
| sys_rst_req | output | 1 | System reset request, one tick long |
| expired | output | 1 | Sticky expiry flag, used when reset is disabled |

## Verification
The countdown is exercised with these loads:
- a small value, to find the exact expiry tick;
- zero, for the first-tick edge case;
- 1638 ticks, which must fire on tick 1638 and not one tick earlier;
- a load whose high half is non-zero, which shows that the upper 16 bits are not dropped.

The countdown is also run with one enable bit missing, so that a tick that must be gated can be told apart from one that counts. Load-low writes made in the middle of a countdown, with and without new-load mode, show whether a reload is taken. Wrong, inverse and correct lock keys confirm which values open and close the guard.

// File: rtl/wdt_guard_pkg.sv
package wdt_guard_pkg;
  localparam int OFS_LOAD_LO = 'h00;
  localparam int OFS_LOAD_HI = 'h04;
  localparam int OFS_CTRL    = 'h08;
  localparam int OFS_LOCK    = 'h20;
  localparam int OFS_MOD_EN  = 'h24;
  localparam int OFS_CLK_EN  = 'h28;
  localparam int OFS_RST_STS = 'h2C;

  localparam logic [15:0] UNLOCK_KEY = 16'hE551;
  localparam logic [7:0]  WDT_CAUSE  = 8'hF0;

  localparam int CTRL_RUN   = 1;
  localparam int CTRL_NEW   = 2;
  localparam int CTRL_RSTEN = 3;
  localparam int CTRL_EXP   = 4;
  localparam int EN_BIT     = 2;

  typedef struct packed {
    logic rst_en;
    logic new_load;
    logic run;
  } ctrl_t;
endpackage

// File: rtl/wdt_lock_gate.sv
module wdt_lock_gate
  import wdt_guard_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          lock_wr,
  input  logic [DW-1:0] wr_data,
  output logic          locked
);
  always_ff @(posedge clk) begin
    if (rst) begin
      locked <= 1'b1;
    end else if (lock_wr) begin
      locked <= (wr_data != DW'(UNLOCK_KEY));
    end
  end
endmodule

// File: rtl/wdt_regfile.sv
module wdt_regfile
  import wdt_guard_pkg::*;
#(
  parameter int DW = 16,
  parameter int AW = 6,
  localparam int LW = 2 * DW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  input  logic          locked,
  input  logic          hw_stop_run,
  input  logic          hw_cause,
  input  logic          expired,
  output logic [DW-1:0] rd_data,
  output logic [LW-1:0] load_val,
  output ctrl_t         ctrl,
  output logic          enabled,
  output logic          lock_wr,
  output logic          newload_req,
  output logic [DW-1:0] rst_status
);
  logic [DW-1:0] load_lo, load_hi, mod_en, clk_en;
  logic          wr_lo, wr_hi, wr_ctrl, wr_mod, wr_clk, wr_sts;
  logic [DW-1:0] sts_next, rd_mux;

  assign wr_lo   = wr_en && !locked && (wr_addr == AW'(OFS_LOAD_LO));
  assign wr_hi   = wr_en && !locked && (wr_addr == AW'(OFS_LOAD_HI));
  assign wr_ctrl = wr_en && !locked && (wr_addr == AW'(OFS_CTRL));
  assign lock_wr = wr_en && (wr_addr == AW'(OFS_LOCK));
  assign wr_mod  = wr_en && (wr_addr == AW'(OFS_MOD_EN));
  assign wr_clk  = wr_en && (wr_addr == AW'(OFS_CLK_EN));
  assign wr_sts  = wr_en && (wr_addr == AW'(OFS_RST_STS));

  assign load_val = {load_hi, load_lo};
  assign enabled  = mod_en[EN_BIT] && clk_en[EN_BIT];

  always_comb begin
    sts_next = wr_sts ? wr_data : rst_status;
    if (hw_cause) sts_next[7:0] = WDT_CAUSE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      load_lo     <= '0;
      load_hi     <= '0;
      ctrl        <= '0;
      mod_en      <= '0;
      clk_en      <= '0;
      rst_status  <= '0;
      newload_req <= 1'b0;
    end else begin
      if (wr_lo) load_lo <= wr_data;
      if (wr_hi) load_hi <= wr_data;
      if (wr_mod) mod_en <= wr_data;
      if (wr_clk) clk_en <= wr_data;
      rst_status <= sts_next;
      if (wr_ctrl) begin
        ctrl.run      <= wr_data[CTRL_RUN];
        ctrl.new_load <= wr_data[CTRL_NEW];
        ctrl.rst_en   <= wr_data[CTRL_RSTEN];
      end
      if (hw_stop_run) ctrl.run <= 1'b0;
      newload_req <= wr_lo && ctrl.new_load;
    end
  end

  always_comb begin
    rd_mux = '0;
    case (rd_addr)
      AW'(OFS_LOAD_LO): rd_mux = load_lo;
      AW'(OFS_LOAD_HI): rd_mux = load_hi;
      AW'(OFS_CTRL): begin
        rd_mux[CTRL_RUN]   = ctrl.run;
        rd_mux[CTRL_NEW]   = ctrl.new_load;
        rd_mux[CTRL_RSTEN] = ctrl.rst_en;
        rd_mux[CTRL_EXP]   = expired;
      end
      AW'(OFS_LOCK):    rd_mux[0] = locked;
      AW'(OFS_MOD_EN):  rd_mux = mod_en;
      AW'(OFS_CLK_EN):  rd_mux = clk_en;
      AW'(OFS_RST_STS): rd_mux = rst_status;
      default:          rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else if (rd_en) rd_data <= rd_mux;
  end
endmodule

// File: rtl/wdt_countdown.sv
module wdt_countdown #(
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          run,
  input  logic          enabled,
  input  logic          newload_req,
  input  logic [CW-1:0] load_val,
  output logic          reload,
  output logic          expire
);
  logic [CW-1:0] cnt;
  logic          run_q, armed, step;

  assign reload = (run && !run_q) || (newload_req && run);
  assign step   = tick && run && enabled && armed && !reload;
  assign expire = step && (cnt <= CW'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      run_q <= 1'b0;
      armed <= 1'b0;
    end else begin
      run_q <= run;
      if (reload) begin
        cnt   <= load_val;
        armed <= 1'b1;
      end else if (expire) begin
        cnt   <= '0;
        armed <= 1'b0;
      end else if (step) begin
        cnt <= cnt - CW'(1);
      end
    end
  end
endmodule

// File: rtl/wdt_reset_pulse.sv
module wdt_reset_pulse (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic expire,
  input  logic rst_en,
  input  logic reload,
  output logic rst_req,
  output logic expired
);
  always_ff @(posedge clk) begin
    if (rst) begin
      rst_req <= 1'b0;
      expired <= 1'b0;
    end else begin
      if (expire && rst_en) rst_req <= 1'b1;
      else if (tick) rst_req <= 1'b0;
      if (reload) expired <= 1'b0;
      else if (expire && !rst_en) expired <= 1'b1;
    end
  end
endmodule

// File: rtl/wdt_lockable_reset.sv
module wdt_lockable_reset
  import wdt_guard_pkg::*;
#(
  parameter int DW = 16,
  parameter int AW = 6,
  localparam int LW = 2 * DW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  output logic          sys_rst_req,
  output logic          expired
);
  logic          locked, lock_wr, enabled, newload_req, reload, expire, hw_stop;
  logic [LW-1:0] load_val;
  logic [DW-1:0] rst_status;
  ctrl_t         ctrl_q;

  assign hw_stop = expire && ctrl_q.rst_en;

  wdt_lock_gate #(.DW(DW)) u_lock (
    .clk(clk), .rst(rst), .lock_wr(lock_wr), .wr_data(wr_data), .locked(locked)
  );

  wdt_regfile #(.DW(DW), .AW(AW)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .locked(locked), .hw_stop_run(hw_stop),
    .hw_cause(hw_stop), .expired(expired), .rd_data(rd_data), .load_val(load_val),
    .ctrl(ctrl_q), .enabled(enabled), .lock_wr(lock_wr), .newload_req(newload_req),
    .rst_status(rst_status)
  );

  wdt_countdown #(.CW(LW)) u_cnt (
    .clk(clk), .rst(rst), .tick(tick), .run(ctrl_q.run), .enabled(enabled),
    .newload_req(newload_req), .load_val(load_val), .reload(reload), .expire(expire)
  );

  wdt_reset_pulse u_pulse (
    .clk(clk), .rst(rst), .tick(tick), .expire(expire), .rst_en(ctrl_q.rst_en),
    .reload(reload), .rst_req(sys_rst_req), .expired(expired)
  );
endmodule

// File: rtl/wdt_guard_chk.sv
module wdt_guard_chk
  import wdt_guard_pkg::*;
#(
  parameter int DW = 16,
  parameter int AW = 6,
  localparam int LW = 2 * DW
) (
  input logic          clk,
  input logic          rst,
  input logic          tick,
  input logic          wr_en,
  input logic [AW-1:0] wr_addr,
  input logic [DW-1:0] wr_data,
  input logic          locked,
  input logic [LW-1:0] load_val,
  input logic          run,
  input logic          rst_en,
  input logic [DW-1:0] rst_status,
  input logic          rst_req,
  input logic          expired
);
  AST_LOCKED_LOAD_HOLD: assert property (@(posedge clk) disable iff (rst)
    (locked && wr_en && (wr_addr == AW'(OFS_LOAD_LO) || wr_addr == AW'(OFS_LOAD_HI)))
      |=> $stable(load_val)); // R2
  AST_KEY_OPENS: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == AW'(OFS_LOCK) && wr_data == DW'(UNLOCK_KEY)) |=> !locked); // R2
  AST_REQ_RISES_ON_TICK: assert property (@(posedge clk) disable iff (rst)
    $rose(rst_req) |-> $past(tick)); // R6
  AST_REQ_FALLS_ON_TICK: assert property (@(posedge clk) disable iff (rst)
    $fell(rst_req) |-> $past(tick)); // R6
  AST_REQ_STOPS_RUN: assert property (@(posedge clk) disable iff (rst)
    $rose(rst_req) |-> (!run && $past(rst_en))); // R6
  AST_CAUSE_CODE: assert property (@(posedge clk) disable iff (rst)
    $rose(rst_req) |-> (rst_status[7:0] == WDT_CAUSE)); // R7
  AST_FLAG_NOT_WITH_REQ: assert property (@(posedge clk) disable iff (rst)
    $rose(expired) |-> !$rose(rst_req)); // R8
endmodule

bind wdt_lockable_reset wdt_guard_chk #(.DW(DW), .AW(AW)) u_chk (
  .clk(clk), .rst(rst), .tick(tick), .wr_en(wr_en), .wr_addr(wr_addr),
  .wr_data(wr_data), .locked(locked), .load_val(load_val), .run(ctrl_q.run),
  .rst_en(ctrl_q.rst_en), .rst_status(rst_status), .rst_req(sys_rst_req),
  .expired(expired)
);

// File: tb/tb_wdt_lockable_reset.sv
module tb_wdt_lockable_reset;
  localparam logic [5:0] A_LO = 6'h00, A_HI = 6'h04, A_CTRL = 6'h08, A_LOCK = 6'h20,
                         A_MOD = 6'h24, A_CLK = 6'h28, A_STS = 6'h2C;

  logic clk = 1'b0, rst = 1'b1, tick = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [5:0] wr_addr = '0, rd_addr = '0;
  logic [15:0] wr_data = '0, rd_data;
  logic sys_rst_req, expired;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  wdt_lockable_reset dut (
    .clk(clk), .rst(rst), .tick(tick), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .sys_rst_req(sys_rst_req), .expired(expired)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [5:0] a, input logic [15:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic bus_rd(input logic [5:0] a, output logic [15:0] d);
    @(negedge clk); rd_en = 1'b1; rd_addr = a;
    @(negedge clk); rd_en = 1'b0; d = rd_data;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  task automatic t_reset();
    logic [15:0] d;
    bus_rd(A_LOCK, d); chk("R1 lock", d, 1);
    bus_rd(A_CTRL, d); chk("R1 ctrl", d, 0);
    bus_rd(A_LO, d);   chk("R1 load lo", d, 0);
    bus_rd(A_HI, d);   chk("R1 load hi", d, 0);
    bus_rd(A_STS, d);  chk("R1 status", d, 0);
    chk("R1 req", sys_rst_req, 0);
    chk("R1 expired", expired, 0);
  endtask

  task automatic t_lock();
    logic [15:0] d;
    bus_wr(A_LO, 16'h1234); bus_rd(A_LO, d); chk("R2 locked write dropped", d, 0);
    bus_wr(A_LOCK, 16'hE551); bus_rd(A_LOCK, d); chk("R2 key unlocks", d, 0);
    bus_wr(A_LO, 16'h1234); bus_rd(A_LO, d); chk("R3 load lo readback", d, 16'h1234);
    bus_wr(A_LOCK, 16'h1AAE); bus_rd(A_LOCK, d); chk("R2 inverse key locks", d, 1);
    bus_wr(A_LO, 16'h5555); bus_wr(A_CTRL, 16'h000E);
    bus_rd(A_LO, d); chk("R2 load kept while locked", d, 16'h1234);
    bus_rd(A_CTRL, d); chk("R2 ctrl kept while locked", d, 0);
    bus_wr(A_STS, 16'h1203); bus_rd(A_STS, d); chk("R3 status ignores lock", d, 16'h1203);
    bus_wr(A_LOCK, 16'hE551); bus_wr(A_LOCK, 16'h0042);
    bus_rd(A_LOCK, d); chk("R2 other value locks", d, 1);
    bus_wr(A_LOCK, 16'hE551);
  endtask

  task automatic t_gate_and_reset();
    logic [15:0] d;
    bus_wr(A_CLK, 16'h0004); bus_wr(A_MOD, 16'h0000);
    bus_wr(A_LO, 16'd3); bus_wr(A_HI, 16'd0); bus_wr(A_CTRL, 16'h000A);
    ticks(5); chk("R4 no count with module enable clear", sys_rst_req, 0);
    bus_wr(A_MOD, 16'h0004);
    ticks(2); chk("R5 not yet at tick 2", sys_rst_req, 0);
    ticks(1); chk("R5 expiry at tick 3", sys_rst_req, 1);
    repeat (3) @(negedge clk);
    chk("R6 request held between ticks", sys_rst_req, 1);
    bus_rd(A_CTRL, d); chk("R6 run cleared", d, 16'h0008);
    bus_rd(A_STS, d); chk("R7 cause code", d, 16'h12F0);
    ticks(1); chk("R6 request drops at next tick", sys_rst_req, 0);
  endtask

  task automatic t_no_reset();
    logic [15:0] d;
    bus_wr(A_STS, 16'h0000); bus_wr(A_CTRL, 16'h0000);
    bus_wr(A_LO, 16'd2); bus_wr(A_CTRL, 16'h0002);
    ticks(2);
    chk("R8 flag set", expired, 1);
    chk("R8 no request", sys_rst_req, 0);
    bus_rd(A_CTRL, d); chk("R8 ctrl bit4", d, 16'h0012);
    ticks(3);
    chk("R8 flag sticky", expired, 1);
    chk("R8 still no request", sys_rst_req, 0);
    bus_rd(A_STS, d); chk("R7 status unchanged without reset", d, 0);
    bus_wr(A_CTRL, 16'h0000); bus_wr(A_CTRL, 16'h0002);
    @(negedge clk); chk("R8 flag cleared on run rise", expired, 0);
    bus_wr(A_CTRL, 16'h0000);
  endtask

  task automatic t_loads();
    bus_wr(A_LO, 16'd0); bus_wr(A_CTRL, 16'h000A);
    ticks(1); chk("R5 zero load first tick", sys_rst_req, 1);
    ticks(1);
    bus_wr(A_LO, 16'd1638); bus_wr(A_CTRL, 16'h000A);
    ticks(1637); chk("R5 50ms load not early", sys_rst_req, 0);
    ticks(1); chk("R5 50ms load fires", sys_rst_req, 1);
    ticks(1);
    bus_wr(A_HI, 16'd1); bus_wr(A_LO, 16'd2); bus_wr(A_CTRL, 16'h000A);
    ticks(3); chk("R5 high half counts", sys_rst_req, 0);
    bus_wr(A_CTRL, 16'h0000); bus_wr(A_HI, 16'd0);
  endtask

  task automatic t_newload();
    bus_wr(A_LO, 16'd100); bus_wr(A_CTRL, 16'h000E);
    ticks(2);
    bus_wr(A_LO, 16'd2);
    ticks(1); chk("R9 reloaded, one left", sys_rst_req, 0);
    ticks(1); chk("R9 new-load reload expiry", sys_rst_req, 1);
    ticks(1);
    bus_wr(A_CTRL, 16'h0000); bus_wr(A_LO, 16'd3); bus_wr(A_CTRL, 16'h000A);
    ticks(1); bus_wr(A_LO, 16'd50);
    ticks(1); chk("R9 no reload without mode", sys_rst_req, 0);
    ticks(1); chk("R9 original count expires", sys_rst_req, 1);
    ticks(1);
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog timeout actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_lock();
    t_gate_and_reset();
    t_no_reset();
    t_loads();
    t_newload();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule